// File: doc/BRIEF.md
# Breakpoint Register File with Access Checking

This block holds the hardware breakpoint state of a processor core: four breakpoint address registers, a 32-bit status register and a 32-bit control register. The core reaches these registers only through register-move requests. Each request carries a 3-bit register index, a direction (read or write) and, for a write, a data word. The core also supplies its execution context with each request: whether it is in real mode, whether it is in 64-bit mode, its current privilege level, and whether the debug-extension enable is set.

Each request is checked before it completes. A request that fails a check raises exactly one fault output: undefined opcode, general protection or debug. A faulting request changes no register and returns no data. An accepted write is shaped by fixed per-register masks. A write to an address register also pulses a page-invalidate strobe that carries the written address. A control write updates a code-breakpoint-armed level and can pulse a length warning.

Every result is registered. Each result appears on the outputs one clock after the request is sampled and lasts for one cycle. The armed level and the pending register-access flag are the exceptions: they hold their value.

Top module: `brkpt_regfile`

## Requirements
- R1: After reset, address registers 0 to 3 read 0, the status register (index 6) reads 0xFFFF0FF0, the control register (index 7) reads 0x00000400, and every fault, strobe and flag output is 0.
- R2: An accepted write to index 0 to 3 stores the full data word. One cycle later it raises invStrobe for one cycle, with invAddr equal to the written word. A later read of that index returns the same word.
- R3: An accepted status write replaces only bits 15:13 and 3:0 with the written data and keeps the other bits. Bit 12 therefore always reads 0.
- R4: An accepted control write stores (data AND 0xFFFF2FFF) OR 0x00000400. Bits 15, 14 and 12 always read 0, and bit 10 always reads 1.
- R5: With extEnable low, index 4 reads and writes the status register and index 5 reads and writes the control register.
- R6: With extEnable high, any request to index 4 or 5 raises faultUndef and changes nothing.
- R7: While control bit 13 (general detect) is set, every request raises faultDebug and changes nothing. The pendAccess output is set and stays set until reset.
- R8: When realMode is low and privLevel is not 0, a request raises faultGp and changes nothing. When realMode is high, privLevel is not checked.
- R9: With longMode high, a write to the status or control register (index 4 to 7 after aliasing) with any nonzero bit above bit 31 raises faultGp and changes nothing.
- R10: After each accepted control write, codeBpArmed is 1 exactly when stored bits 7:0 are not all zero and at least one type field (bits 17:16, 21:20, 25:24, 29:28) is 00.
- R11: An accepted control write pulses lenWarn for one cycle when some type field is 00 and its length field (bits 19:18, 23:22, 27:26, 31:30, paired in that order) is nonzero. The write is still stored.
- R12: A request raises at most one fault. The checks are applied in this order: alias fault, then general detect, then privilege, then the upper-bit check. A faulting read raises no rspValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIndex | input | 3 | Register index |
| reqData | input | ADDR_W | Write data |
| extEnable | input | 1 | Debug-extension enable |
| realMode | input | 1 | Core is in real mode |
| longMode | input | 1 | Core is in 64-bit mode |
| privLevel | input | 2 | Current privilege level |
| rspValid | output | 1 | Read data valid pulse |
| rspData | output | ADDR_W | Read data; status and control are zero-extended |
| faultUndef | output | 1 | Undefined-opcode fault pulse |
| faultGp | output | 1 | General-protection fault pulse |
| faultDebug | output | 1 | Debug fault pulse |
| pendAccess | output | 1 | Sticky pending-debug register-access flag |
| invStrobe | output | 1 | Page-invalidate pulse |
| invAddr | output | ADDR_W | Address to invalidate |
| codeBpArmed | output | 1 | Code breakpoint armed level |
| lenWarn | output | 1 | Type/length mismatch warning pulse |

## Verification
A request sampled on a rising edge produces its results on the outputs one cycle later:
- rspData and rspValid
- the three fault pulses
- invStrobe with invAddr
- lenWarn
- the updated codeBpArmed and pendAccess

The bench drives each request on a falling edge and removes it on the next falling edge. It reads every output at that moment, which is exactly one register stage after the capturing edge. A request with no effect is shown at the ports by the absence of strobes and by reading the target register back afterwards. The one exception is the general-detect case: there every access is blocked, so the absence of strobes and response data is the observable evidence.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_UNDEF = 2'd1,
    FLT_DEBUG = 2'd2,
    FLT_GP    = 2'd3
  } fault_e;

  // Control-to-datapath strobes for one request
  typedef struct packed {
    logic [3:0] wrAddr;
    logic       wrStatus;
    logic       wrControl;
    logic       rdEn;
    logic [2:0] rdIdx;
    fault_e     fault;
  } strobe_t;

  localparam logic [31:0] STATUS_KEEP  = 32'hFFFF_0FF0;
  localparam logic [31:0] STATUS_TAKE  = 32'h0000_E00F;
  localparam logic [31:0] STATUS_RESET = 32'hFFFF_0FF0;
  localparam logic [31:0] CTRL_AND     = 32'hFFFF_2FFF;
  localparam logic [31:0] CTRL_OR      = 32'h0000_0400;
  localparam int          GD_BIT       = 13;
  localparam int          NUM_SLOTS    = 4;

endpackage

// File: rtl/brkpt_ctrl.sv
module brkpt_ctrl
  import brkpt_pkg::*;
#(
  parameter int HI_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [2:0]      reqIndex,
  input  logic [HI_W-1:0] reqHi,
  input  logic            extEnable,
  input  logic            realMode,
  input  logic            longMode,
  input  logic [1:0]      privLevel,
  input  logic            gdBit,
  output strobe_t         strobe,
  output logic            faultUndef,
  output logic            faultGp,
  output logic            faultDebug,
  output logic            pendAccess
);

  logic [2:0] effIdx;
  logic       aliasHit;
  logic       isSys;

  always_comb begin
    aliasHit = (reqIndex[2:1] == 2'b10);
    effIdx   = aliasHit ? {2'b11, reqIndex[0]} : reqIndex;
    isSys    = (effIdx[2:1] == 2'b11);
  end

  // Fault priority: alias, general detect, privilege, upper bits
  always_comb begin
    strobe       = '0;
    strobe.fault = FLT_NONE;
    if (reqValid) begin
      if (extEnable && aliasHit) begin
        strobe.fault = FLT_UNDEF;
      end else if (gdBit) begin
        strobe.fault = FLT_DEBUG;
      end else if (!realMode && (privLevel != 2'd0)) begin
        strobe.fault = FLT_GP;
      end else if (reqWrite && longMode && isSys && (|reqHi)) begin
        strobe.fault = FLT_GP;
      end else if (reqWrite) begin
        if (!effIdx[2]) strobe.wrAddr[effIdx[1:0]] = 1'b1;
        strobe.wrStatus  = (effIdx == 3'd6);
        strobe.wrControl = (effIdx == 3'd7);
      end else begin
        strobe.rdEn  = 1'b1;
        strobe.rdIdx = effIdx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultUndef <= 1'b0;
      faultGp    <= 1'b0;
      faultDebug <= 1'b0;
      pendAccess <= 1'b0;
    end else begin
      faultUndef <= (strobe.fault == FLT_UNDEF);
      faultGp    <= (strobe.fault == FLT_GP);
      faultDebug <= (strobe.fault == FLT_DEBUG);
      if (strobe.fault == FLT_DEBUG) pendAccess <= 1'b1;
    end
  end

endmodule

// File: rtl/brkpt_dpath.sv
module brkpt_dpath
  import brkpt_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] reqData,
  output logic              gdBit,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspData,
  output logic              invStrobe,
  output logic [ADDR_W-1:0] invAddr,
  output logic              codeBpArmed,
  output logic              lenWarn
);

  localparam int PAD_W = ADDR_W - 32;

  logic [ADDR_W-1:0] addrRegs [NUM_SLOTS];
  logic [31:0]       statusReg;
  logic [31:0]       ctrlReg;
  logic [31:0]       newCtrl;
  logic [NUM_SLOTS-1:0] typeZero;
  logic [NUM_SLOTS-1:0] lenBad;
  logic [ADDR_W-1:0] rdMux;

  assign newCtrl = (reqData[31:0] & CTRL_AND) | CTRL_OR;
  assign gdBit   = ctrlReg[GD_BIT];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign typeZero[s] = (newCtrl[16 + 4*s +: 2] == 2'b00);
    assign lenBad[s]   = typeZero[s] && (newCtrl[18 + 4*s +: 2] != 2'b00);

    always_ff @(posedge clk) begin
      if (!rstN)                 addrRegs[s] <= '0;
      else if (strobe.wrAddr[s]) addrRegs[s] <= reqData;
    end
  end

  always_comb begin
    rdMux = '0;
    if (!strobe.rdIdx[2])            rdMux = addrRegs[strobe.rdIdx[1:0]];
    else if (strobe.rdIdx == 3'd6)   rdMux = {{PAD_W{1'b0}}, statusReg};
    else if (strobe.rdIdx == 3'd7)   rdMux = {{PAD_W{1'b0}}, ctrlReg};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg   <= STATUS_RESET;
      ctrlReg     <= CTRL_OR;
      rspValid    <= 1'b0;
      rspData     <= '0;
      invStrobe   <= 1'b0;
      invAddr     <= '0;
      codeBpArmed <= 1'b0;
      lenWarn     <= 1'b0;
    end else begin
      rspValid  <= strobe.rdEn;
      invStrobe <= |strobe.wrAddr;
      lenWarn   <= strobe.wrControl && (|lenBad);
      if (strobe.rdEn) rspData <= rdMux;
      if (|strobe.wrAddr) invAddr <= reqData;
      if (strobe.wrStatus)
        statusReg <= (statusReg & STATUS_KEEP) | (reqData[31:0] & STATUS_TAKE);
      if (strobe.wrControl) begin
        ctrlReg     <= newCtrl;
        codeBpArmed <= (|newCtrl[7:0]) && (|typeZero);
      end
    end
  end

endmodule

// File: rtl/brkpt_regfile.sv
module brkpt_regfile
  import brkpt_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [2:0]        reqIndex,
  input  logic [ADDR_W-1:0] reqData,
  input  logic              extEnable,
  input  logic              realMode,
  input  logic              longMode,
  input  logic [1:0]        privLevel,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspData,
  output logic              faultUndef,
  output logic              faultGp,
  output logic              faultDebug,
  output logic              pendAccess,
  output logic              invStrobe,
  output logic [ADDR_W-1:0] invAddr,
  output logic              codeBpArmed,
  output logic              lenWarn
);

  localparam int HI_W = ADDR_W - 32;

  strobe_t strobe;
  logic    gdBit;

  brkpt_ctrl #(.HI_W(HI_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqIndex   (reqIndex),
    .reqHi      (reqData[ADDR_W-1:32]),
    .extEnable  (extEnable),
    .realMode   (realMode),
    .longMode   (longMode),
    .privLevel  (privLevel),
    .gdBit      (gdBit),
    .strobe     (strobe),
    .faultUndef (faultUndef),
    .faultGp    (faultGp),
    .faultDebug (faultDebug),
    .pendAccess (pendAccess)
  );

  brkpt_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqData     (reqData),
    .gdBit       (gdBit),
    .rspValid    (rspValid),
    .rspData     (rspData),
    .invStrobe   (invStrobe),
    .invAddr     (invAddr),
    .codeBpArmed (codeBpArmed),
    .lenWarn     (lenWarn)
  );

endmodule

// File: rtl/brkpt_regfile_chk.sv
module brkpt_regfile_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [2:0]        reqIndex,
  input logic [ADDR_W-1:0] reqData,
  input logic              extEnable,
  input logic              rspValid,
  input logic              faultUndef,
  input logic              faultGp,
  input logic              faultDebug,
  input logic              pendAccess,
  input logic              invStrobe,
  input logic [ADDR_W-1:0] invAddr,
  input logic              lenWarn
);

  assert_inv_after_addr_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    invStrobe |-> $past(reqValid && reqWrite && !reqIndex[2]));

  assert_inv_carries_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    invStrobe |-> (invAddr == $past(reqData)));

  assert_undef_only_alias_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultUndef |-> $past(reqValid && extEnable && (reqIndex[2:1] == 2'b10)));

  assert_debug_sets_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultDebug |-> pendAccess);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    pendAccess |=> pendAccess);

  assert_warn_on_ctrl_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    lenWarn |-> $past(reqValid && reqWrite && reqIndex[2] && reqIndex[0]));

  assert_single_fault_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({faultUndef, faultGp, faultDebug}));

  assert_no_data_on_fault_R12: assert property (@(posedge clk) disable iff (!rstN)
    (faultUndef || faultGp || faultDebug) |-> !(rspValid || invStrobe || lenWarn));

endmodule

bind brkpt_regfile brkpt_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqIndex   (reqIndex),
  .reqData    (reqData),
  .extEnable  (extEnable),
  .rspValid   (rspValid),
  .faultUndef (faultUndef),
  .faultGp    (faultGp),
  .faultDebug (faultDebug),
  .pendAccess (pendAccess),
  .invStrobe  (invStrobe),
  .invAddr    (invAddr),
  .lenWarn    (lenWarn)
);

// File: tb/brkpt_regfile_bench.sv
module brkpt_regfile_bench;

  localparam int ADDR_W = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [2:0]        reqIndex = '0;
  logic [ADDR_W-1:0] reqData = '0;
  logic              extEnable = 1'b0;
  logic              realMode = 1'b0;
  logic              longMode = 1'b0;
  logic [1:0]        privLevel = 2'd0;
  logic              rspValid, faultUndef, faultGp, faultDebug, pendAccess;
  logic              invStrobe, codeBpArmed, lenWarn;
  logic [ADDR_W-1:0] rspData, invAddr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  brkpt_regfile #(.ADDR_W(ADDR_W)) u_brkpt_regfile (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, outputs are read one rising edge later
  task automatic access(input bit wr, input logic [2:0] idx, input logic [63:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqIndex = idx; reqData = data;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  function automatic logic [3:0] faults();
    return {rspValid, faultUndef, faultGp, faultDebug};
  endfunction

  task automatic t_reset();
    chk("R1 pulses/flags", {faultUndef, faultGp, faultDebug, pendAccess, invStrobe, codeBpArmed, lenWarn}, 0);
    for (int i = 0; i < 4; i++) begin
      access(0, 3'(i), 0);
      chk("R1 address reg", rspData, 0);
    end
    access(0, 6, 0); chk("R1 status", rspData, 64'hFFFF0FF0);
    access(0, 7, 0); chk("R1 control", rspData, 64'h400);
  endtask

  task automatic t_addr();
    longMode = 1;
    access(1, 2, 64'h1234_5678_9ABC_DEF0);
    chk("R2 inv strobe", invStrobe, 1);
    chk("R2 inv addr", invAddr, 64'h1234_5678_9ABC_DEF0);
    access(0, 2, 0);
    chk("R2 readback", rspData, 64'h1234_5678_9ABC_DEF0);
    chk("R2 strobe one cycle", invStrobe, 0);
    longMode = 0;
  endtask

  task automatic t_status();
    realMode = 1; privLevel = 3;  // R8: real mode ignores privilege
    access(1, 6, 64'hFFFF_FFFF);
    chk("R8 real mode no fault", faults(), 0);
    access(0, 6, 0); chk("R3 status all ones", rspData, 64'hFFFFEFFF);
    access(1, 6, 0);
    access(0, 6, 0); chk("R3 status zero", rspData, 64'hFFFF0FF0);
    realMode = 0; privLevel = 0;
  endtask

  task automatic t_control();
    access(1, 7, 64'hFFFF_DFFF);
    access(0, 7, 0); chk("R4 control mask", rspData, 64'hFFFF0FFF);
    chk("R10 armed off, no 00 type", codeBpArmed, 0);
    access(1, 7, 0);
    chk("R10 armed off, no enables", codeBpArmed, 0);
    access(0, 7, 0); chk("R4 control zero", rspData, 64'h400);
  endtask

  task automatic t_alias();
    access(1, 4, 64'h1);
    access(0, 6, 0); chk("R5 index4 writes status", rspData, 64'hFFFF0FF1);
    access(0, 4, 0); chk("R5 index4 reads status", rspData, 64'hFFFF0FF1);
    access(1, 5, 64'h2);
    chk("R10 armed on", codeBpArmed, 1);
    access(0, 7, 0); chk("R5 index5 writes control", rspData, 64'h402);
    access(1, 7, 64'h3333_0003);
    chk("R10 armed off all types set", codeBpArmed, 0);
    chk("R11 no warn", lenWarn, 0);
    access(1, 7, 64'h0004_0001);
    chk("R11 warn pulse", lenWarn, 1);
    chk("R10 armed with warn", codeBpArmed, 1);
    access(0, 7, 0); chk("R11 write still stored", rspData, 64'h00040401);
  endtask

  task automatic t_undef();
    extEnable = 1;
    access(0, 4, 0); chk("R6 read faults", faults(), 4'b0100);
    realMode = 0; privLevel = 3;
    access(1, 5, 64'h0);
    chk("R12 undef beats gp", faults(), 4'b0100);
    privLevel = 0; extEnable = 0;
    access(0, 7, 0); chk("R6 control unchanged", rspData, 64'h00040401);
  endtask

  task automatic t_priv();
    privLevel = 3;
    access(0, 0, 0); chk("R8 read gp", faults(), 4'b0010);
    access(1, 1, 64'hDEAD);
    chk("R8 write gp", faults(), 4'b0010);
    chk("R8 no inv", invStrobe, 0);
    privLevel = 0;
    access(0, 1, 0); chk("R8 addr1 unchanged", rspData, 0);
  endtask

  task automatic t_upper();
    longMode = 1;
    access(1, 6, 64'h1_0000_000F);
    chk("R9 status upper gp", faults(), 4'b0010);
    access(1, 5, 64'h8000_0000_0000_0000);
    chk("R9 control alias upper gp", faults(), 4'b0010);
    longMode = 0;
    access(0, 6, 0); chk("R9 status unchanged", rspData, 64'hFFFF0FF1);
    access(0, 7, 0); chk("R9 control unchanged", rspData, 64'h00040401);
  endtask

  task automatic t_gd();
    access(1, 7, 64'h2000);
    chk("R7 flag before", pendAccess, 0);
    privLevel = 3;
    access(0, 0, 0); chk("R12 debug beats gp", faults(), 4'b0001);
    chk("R7 flag set", pendAccess, 1);
    privLevel = 0;
    access(1, 0, 64'h55);
    chk("R7 write blocked", {faults(), invStrobe}, 5'b00010);
    extEnable = 1;
    access(0, 5, 0); chk("R12 undef beats debug", faults(), 4'b0100);
    chk("R7 flag sticky", pendAccess, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_addr();
    t_status();
    t_control();
    t_alias();
    t_undef();
    t_priv();
    t_upper();
    t_gd();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule